// File: doc/BRIEF.md
# Multi-Spark Ignition Burst Controller

This block turns a raw breaker-contact signal into an ignition trigger line. Each contact opening (a rising edge on the input) is stretched into a clean pulse of fixed length, 2 ms. Contact bounce during that pulse has no effect. The pulse reaches the output one clock after the edge. The first spark therefore keeps the timing set by the contacts, with no oscillator in the path.

The block also measures the time between openings with an 8-bit millisecond counter. At each new opening the measured value moves into a down-counter, which then runs at twice the measuring rate. The down-counter reaches zero after half of the previous period. During that half period the block adds a train of extra 2 ms pulses to the output. The train runs only if the previous period was at least 16 ms, which means the upper four bits of the count were not all zero. Above roughly 2000 rpm the output carries only the single shaped pulse.

The 0.5 ms and 1 ms timing steps come from an internal clock divider. The divider is set by the number of clock cycles in 0.5 ms.

Top module: `multispark_ctrl`

## Requirements
- R1: A rising edge on `points_i` sampled at a clock edge sets `spark_o` high at that same edge. The output is visible one clock after the input rises.
- R2: The shaped pulse lasts exactly 4 × HALF_MS_CLKS clocks (2 ms). Rising edges on `points_i` while the pulse is high are ignored. They neither lengthen it nor restart the measurement.
- R3: The period counter advances once per 1 ms step whenever no shaped pulse is in progress. It saturates at 255 instead of wrapping, so a 300 ms period gives the same burst as a 255 ms period (32 extra pulses).
- R4: At each accepted opening, the period count is copied into the down-counter and the period counter is cleared. Each interval is therefore measured on its own, independent of earlier intervals and of bounce.
- R5: The down-counter decrements once per 0.5 ms step outside the shaped pulse. The burst window closes when it reaches zero, after half of the copied period. With a 34 ms count the window holds exactly 4 extra pulses.
- R6: The burst window opens only when bits [7:4] of the copied count are not all zero. A count of 15 gives no extra pulse. A count of 16 gives two.
- R7: Within the window, extra pulses are 2 ms high with 2 ms low gaps. The first pulse starts 2 ms after the shaped pulse ends. A pulse still high when the window closes is cut short.
- R8: After reset, the first opening produces only the shaped pulse. It loads the counter but never opens a burst window.
- R9: `spark_o` is the OR of the shaped pulse and the extra pulses. It is low after reset while the input stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| points_i | input | 1 | Raw breaker-contact level, high while open, synchronous to `clk` |
| spark_o | output | 1 | Ignition trigger: shaped pulse OR extra burst pulses |

## Verification
The shaped pulse appears at the first clock edge after the input rises. The bench therefore drives the input at a falling clock edge and samples `spark_o` from the next falling edge onward. It expects exactly 16 high samples with HALF_MS_CLKS = 4.

Extra pulses are due 32 samples after the opening. That is 16 samples of shaped pulse plus a 16-sample gap. The window close depends on where the divider phase falls, which moves it by up to four clocks. The bench chooses interval lengths so that every pulse count is the same for any divider phase. It checks the truncated pulse only for a length strictly between zero and a full pulse.

Each burst depends on the period that came before it. So every scenario first drives one interval of a chosen length, then observes the next one.

// File: rtl/msk_pkg.sv
// Shared definitions for the multi-spark ignition controller.
package msk_pkg;

    // Phase of the extra-pulse generator: low gap first, then a fired pulse.
    typedef enum logic {
        PH_GAP  = 1'b0,
        PH_FIRE = 1'b1
    } pulse_phase_e;

    // Convert a duration in half-millisecond steps into clock cycles.
    function automatic int halves_to_clks(input int halves, input int half_clks);
        return halves * half_clks;
    endfunction

endpackage

// File: rtl/msk_tick_gen.sv
// Time-base divider.
// Produces a one-clock strobe every HALF_MS_CLKS cycles (0.5 ms) and a
// second strobe on every other one of those (1 ms).
// Assumes HALF_MS_CLKS >= 2. Both strobes are free-running from reset.
module msk_tick_gen #(
    parameter int HALF_MS_CLKS = 50000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_half_o,
    output logic tick_ms_o
);
    localparam int DW = (HALF_MS_CLKS > 1) ? $clog2(HALF_MS_CLKS) : 1;
    localparam logic [DW-1:0] DIV_LAST = DW'(HALF_MS_CLKS - 1);

    logic [DW-1:0] div_q;
    logic          odd_q;

    assign tick_half_o = (div_q == DIV_LAST);
    assign tick_ms_o   = tick_half_o & odd_q;

    // Divider counter and half-step parity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
            odd_q <= 1'b0;
        end else if (tick_half_o) begin
            div_q <= '0;
            odd_q <= ~odd_q;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    AST_MS_EVERY_OTHER_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        tick_half_o |=> (odd_q != $past(odd_q)));  // R5

endmodule

// File: rtl/msk_shaper.sv
// Contact-opening pulse shaper.
// A rising edge on the raw contact level starts a pulse of SHAPE_CLKS cycles.
// Edges seen while the pulse is high are ignored.
// Assumes points_i is already synchronous to clk.
// start_o marks the accepting edge.
// ending_o marks the last cycle of the pulse.
module msk_shaper #(
    parameter int SHAPE_CLKS = 200000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic points_i,
    output logic start_o,
    output logic shaped_o,
    output logic ending_o
);
    localparam int CW = $clog2(SHAPE_CLKS + 1);
    localparam logic [CW-1:0] SHAPE_LAST = CW'(SHAPE_CLKS - 1);

    logic          raw_q;
    logic          shaped_q;
    logic [CW-1:0] cnt_q;

    assign start_o  = points_i & ~raw_q & ~shaped_q;
    assign shaped_o = shaped_q;
    assign ending_o = shaped_q & (cnt_q == '0);

    // Edge history, pulse flag and remaining-length counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q    <= 1'b0;
            shaped_q <= 1'b0;
            cnt_q    <= '0;
        end else begin
            raw_q <= points_i;
            if (start_o) begin
                shaped_q <= 1'b1;
                cnt_q    <= SHAPE_LAST;
            end else if (shaped_q) begin
                if (cnt_q == '0) shaped_q <= 1'b0;
                else             cnt_q    <= cnt_q - 1'b1;
            end
        end
    end

    AST_PULSE_FULL_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shaped_q) |-> (cnt_q == SHAPE_LAST));  // R2
    AST_EDGE_STARTS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (points_i && !raw_q && !shaped_q) |=> shaped_q);  // R1

endmodule

// File: rtl/msk_interval.sv
// Period measurement and burst-window control.
// Counts 1 ms steps outside the shaped pulse, saturating at the counter maximum.
// At each accepted opening it moves the count into a down-counter and clears
// the period counter. It opens the window when the count's upper bits are
// non-zero and a full period has already been measured since reset.
// The down-counter runs on 0.5 ms steps and closes the window on reaching zero.
module msk_interval #(
    parameter int PERIOD_W  = 8,
    parameter int NIBBLE_LO = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic shaped_i,
    input  logic ending_i,
    input  logic tick_half_i,
    input  logic tick_ms_i,
    output logic burst_o
);
    localparam logic [PERIOD_W-1:0] P_MAX = '1;

    logic [PERIOD_W-1:0] period_q;
    logic [PERIOD_W-1:0] down_q;
    logic                primed_q;
    logic                burst_q;
    logic                run;
    logic                long_enough;

    assign run         = ~shaped_i | ending_i;
    assign long_enough = |period_q[PERIOD_W-1:NIBBLE_LO];
    assign burst_o     = burst_q;

    // Measure, hand over at opening, then count the half-period down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_q <= '0;
            down_q   <= '0;
            primed_q <= 1'b0;
            burst_q  <= 1'b0;
        end else if (start_i) begin
            down_q   <= period_q;
            period_q <= '0;
            primed_q <= 1'b1;
            burst_q  <= primed_q & long_enough;
        end else begin
            if (run && tick_ms_i && period_q != P_MAX)
                period_q <= period_q + 1'b1;
            if (run && tick_half_i && down_q != '0) begin
                down_q <= down_q - 1'b1;
                if (down_q == PERIOD_W'(1)) burst_q <= 1'b0;
            end
        end
    end

    AST_PERIOD_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        (period_q == P_MAX && !start_i) |=> (period_q == P_MAX));  // R3
    AST_CLEAR_DURING_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        shaped_i |-> (period_q == '0));  // R4
    AST_WINDOW_NEEDS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        burst_q |-> (down_q != '0));  // R5
    AST_FAST_NO_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !long_enough) |=> !burst_q);  // R6
    AST_FIRST_NO_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !primed_q) |=> !burst_q);  // R8

endmodule

// File: rtl/msk_burst_gen.sv
// Extra-pulse generator.
// While the burst window is open and no shaped pulse is running, it alternates
// a low gap and a high pulse of PULSE_CLKS cycles each, starting with the gap.
// When the window closes or a shaped pulse starts, it drops at once and rearms
// on the gap.
module msk_burst_gen
    import msk_pkg::*;
#(
    parameter int PULSE_CLKS = 200000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic burst_i,
    input  logic shaped_i,
    output logic extra_o
);
    localparam int CW = $clog2(PULSE_CLKS + 1);
    localparam logic [CW-1:0] PH_LAST = CW'(PULSE_CLKS - 1);

    pulse_phase_e  phase_q;
    logic [CW-1:0] cnt_q;
    logic          active;

    assign active  = burst_i & ~shaped_i;
    assign extra_o = active & (phase_q == PH_FIRE);

    // Gap/fire phase sequencing while the window is active.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            phase_q <= PH_GAP;
            cnt_q   <= '0;
        end else if (cnt_q == PH_LAST) begin
            phase_q <= (phase_q == PH_GAP) ? PH_FIRE : PH_GAP;
            cnt_q   <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_PHASE_STARTS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phase_q == PH_FIRE) |-> (cnt_q == '0));  // R7
    AST_IDLE_REARMS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (phase_q == PH_GAP));  // R7

endmodule

// File: rtl/multispark_ctrl.sv
// Multi-spark ignition burst controller, top level.
// Chains the time base, opening shaper, interval logic and extra-pulse
// generator. The trigger output is the shaped pulse ORed with the burst.
// Assumes points_i is synchronous to clk and high while the contacts are open.
module multispark_ctrl
    import msk_pkg::*;
#(
    parameter int HALF_MS_CLKS = 50000,
    parameter int PERIOD_W     = 8,
    parameter int NIBBLE_LO    = 4,
    parameter int SHAPE_HALVES = 4,
    parameter int PULSE_HALVES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic points_i,
    output logic spark_o
);
    localparam int SHAPE_CLKS = halves_to_clks(SHAPE_HALVES, HALF_MS_CLKS);
    localparam int PULSE_CLKS = halves_to_clks(PULSE_HALVES, HALF_MS_CLKS);

    logic tick_half, tick_ms;
    logic start, shaped, ending;
    logic burst, extra;

    msk_tick_gen #(.HALF_MS_CLKS(HALF_MS_CLKS)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick_half_o(tick_half), .tick_ms_o(tick_ms)
    );

    msk_shaper #(.SHAPE_CLKS(SHAPE_CLKS)) u_shape (
        .clk(clk), .rst_n(rst_n), .points_i(points_i),
        .start_o(start), .shaped_o(shaped), .ending_o(ending)
    );

    msk_interval #(.PERIOD_W(PERIOD_W), .NIBBLE_LO(NIBBLE_LO)) u_intv (
        .clk(clk), .rst_n(rst_n), .start_i(start), .shaped_i(shaped),
        .ending_i(ending), .tick_half_i(tick_half), .tick_ms_i(tick_ms),
        .burst_o(burst)
    );

    msk_burst_gen #(.PULSE_CLKS(PULSE_CLKS)) u_burst (
        .clk(clk), .rst_n(rst_n), .burst_i(burst), .shaped_i(shaped),
        .extra_o(extra)
    );

    assign spark_o = shaped | extra;

    AST_NO_EXTRA_IN_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        shaped |-> !extra);  // R9

endmodule

// File: tb/test_multispark_ctrl.sv
// Directed bench: each task drives one interval and checks its own results.
module test_multispark_ctrl;
    localparam int H = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic points = 1'b0;
    logic spark;
    bit   done = 1'b0;

    int total = 0;
    int bad = 0;
    int sh_len, n_ext, first_ext, last_len;

    always #5 clk = ~clk;

    multispark_ctrl #(.HALF_MS_CLKS(H)) i_multispark_ctrl (
        .clk(clk), .rst_n(rst_n), .points_i(points), .spark_o(spark)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One interval: open contacts now, observe `cycles` samples, next opening follows.
    task automatic run_interval(input int cycles, input bit bounce);
        bit prev = 1'b0;
        bit in_sh = 1'b1;
        int cur = 0;
        sh_len = 0; n_ext = 0; first_ext = -1; last_len = 0;
        points = 1'b1;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (in_sh) begin
                if (spark) sh_len++;
                else in_sh = 1'b0;
            end else begin
                if (spark && !prev) begin
                    n_ext++;
                    if (first_ext < 0) first_ext = i;
                    cur = 0;
                end
                if (spark) begin
                    cur++;
                    last_len = cur;
                end
            end
            prev = spark;
            if (bounce) begin
                if (i == 1) points = 1'b0;
                else if (i == 3) points = 1'b1;
                else if (i == 6) points = 1'b0;
            end else if (i == 3) begin
                points = 1'b0;
            end
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R9 idle output after reset", spark, 0);
    endtask

    task automatic t_first();
        run_interval(288, 1'b0);
        check("R1 spark on first sample", (sh_len > 0) ? 1 : 0, 1);
        check("R2 shaped length", sh_len, 16);
        check("R8 no burst after reset", n_ext, 0);
    endtask

    task automatic t_burst();
        run_interval(288, 1'b0);
        check("R5 pulses in half of 34 ms", n_ext, 4);
        check("R7 first extra after 2 ms gap", first_ext, 32);
        check("R7 full extra width", last_len, 16);
        check("R9 shaped then extras", sh_len, 16);
    endtask

    task automatic t_bounce();
        run_interval(288, 1'b1);
        check("R2 bounce ignored, length kept", sh_len, 16);
        run_interval(288, 1'b0);
        check("R4 period after bounce", n_ext, 4);
    endtask

    task automatic t_threshold();
        run_interval(136, 1'b0);
        run_interval(144, 1'b0);
        check("R6 count 15 gives no burst", n_ext, 0);
        run_interval(288, 1'b0);
        check("R6 count 16 gives burst", n_ext, 2);
    endtask

    task automatic t_cut();
        run_interval(320, 1'b0);
        run_interval(288, 1'b0);
        check("R7 pulses for count 38", n_ext, 5);
        check("R7 last pulse cut short", (last_len > 0 && last_len < 16) ? 1 : 0, 1);
    endtask

    task automatic t_saturate();
        run_interval(2400, 1'b0);
        run_interval(1200, 1'b0);
        check("R3 saturated count burst", n_ext, 32);
        check("R2 shaped length long run", sh_len, 16);
    endtask

    initial begin
        t_reset();
        t_first();
        t_burst();
        t_bounce();
        t_threshold();
        t_cut();
        t_saturate();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule